// File: doc/BRIEF.md
# Interleaved Multi-Bank Read Memory

This block is a word-addressed memory split into several banks. The low-order bits of the word address choose the bank and the upper bits choose the row inside it, so consecutive addresses land in different banks. A stream of vector-element reads can therefore return one element per cycle once the pipeline has filled.

Each bank needs a fixed recovery time after it is accessed. The block keeps one down-counter per bank. When the next request targets a bank that is still recovering, it holds `reqReady` low until that bank is free. Accesses that reach free banks are accepted at once. A stride equal to the bank count keeps hitting the same bank and falls to one element per recovery period. Requests use a valid/ready handshake and may be reads or writes. Writes load the memory and return nothing. Reads return data on a valid-only response port, in request order, with a fixed latency of two cycles.

Top module: `ilv_bank_mem`

## Requirements
- R1: The bank index is the word address modulo `NUM_BANKS` (the low `log2(NUM_BANKS)` address bits). The row is the remaining upper bits. Two addresses that differ by a multiple of `NUM_BANKS` share a bank but hold separate words.
- R2: After a bank accepts an access in cycle t, it accepts no further access before cycle t + `BUSY_CYCLES` (default 4). It accepts one in cycle t + `BUSY_CYCLES` if one is presented.
- R3: `reqReady` is low exactly while the bank addressed by `reqAddr` is recovering. A request to a free bank is accepted in the cycle it is presented, whatever the state of the other banks.
- R4: A read accepted at clock edge t raises `rspValid` after edge t+2, for one cycle. `rspData` then holds the word most recently written to that address.
- R5: Responses leave in the order the reads were accepted. An accepted write (`reqWrite` = 1) produces no response.
- R6: A unit-stride stream held valid on every cycle is accepted at one access per cycle.
- R7: A stream with stride `NUM_BANKS` is accepted at exactly one access every `BUSY_CYCLES` cycles.
- R8: After reset every bank is free, `reqReady` is high, and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request may be accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | DATA_W | Read data |

## Verification
On every cycle, the assertions check the following:
- No bank is accepted twice inside its recovery window.
- A request to a bank that saw no recent access is never stalled.
- Every accepted read yields a response two cycles later.
- No response follows a write.

Other behaviours can only be shown by the bench's scenarios:
- the bank mapping, through data that does not alias between addresses of the same bank;
- the sustained rates of the unit-stride and bank-stride streams;
- the stall pattern of random strides with idle gaps;
- the data returned after interleaved writes.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  // strobes from the bank controller to the datapath
  typedef struct packed {
    logic rdIssue;
    logic wrIssue;
  } ilv_strobe_t;
endpackage

// File: rtl/ilv_bank_ctrl.sv
module ilv_bank_ctrl
  import ilv_mem_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  output logic              reqReady,
  output ilv_strobe_t       strobe
);
  logic [NUM_BANKS-1:0] bankFree;
  logic                 accept;

  assign reqReady = bankFree[reqBank];
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe.rdIssue = accept && !reqWrite;
    strobe.wrIssue = accept && reqWrite;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_busy
    logic [CNT_W-1:0] busyCnt;
    always_ff @(posedge clk) begin
      if (rst)
        busyCnt <= '0;
      else if (accept && (reqBank == BANK_W'(b)))
        busyCnt <= CNT_W'(BUSY_CYCLES - 1);
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
    assign bankFree[b] = (busyCnt == '0);
  end
endmodule

// File: rtl/ilv_bank_data.sv
module ilv_bank_data
  import ilv_mem_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 5,
  parameter int DATA_W    = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROWS     = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ilv_strobe_t       strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] bankOut [NUM_BANKS];
  logic              rdPend;
  logic [BANK_W-1:0] rdBankQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rowQ;
    logic              sel;
    assign sel = (reqBank == BANK_W'(b));
    always_ff @(posedge clk) begin
      if (strobe.wrIssue && sel) mem[reqRow] <= reqWdata;
      if (strobe.rdIssue && sel) rowQ <= mem[reqRow];
    end
    assign bankOut[b] = rowQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPend   <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      rdPend   <= strobe.rdIssue;
      rspValid <= rdPend;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.rdIssue) rdBankQ <= reqBank;
    if (rdPend) rspData <= bankOut[rdBankQ];
  end
endmodule

// File: rtl/ilv_bank_mem.sv
module ilv_bank_mem
  import ilv_mem_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int BUSY_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int ROW_W      = ADDR_W - BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  ilv_strobe_t       strobe;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;

  assign reqBank = reqAddr[BANK_W-1:0];
  assign reqRow  = reqAddr[ADDR_W-1:BANK_W];

  ilv_bank_ctrl #(
    .NUM_BANKS(NUM_BANKS), .BUSY_CYCLES(BUSY_CYCLES)
  ) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqReady(reqReady), .strobe(strobe)
  );

  ilv_bank_data #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .reqBank(reqBank),
    .reqRow(reqRow), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData)
  );
endmodule

// File: rtl/ilv_bank_mem_chk.sv
module ilv_bank_mem_chk #(
  parameter int NUM_BANKS   = 8,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int HIST       = BUSY_CYCLES - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid
);
  logic              acc, accRd;
  logic [BANK_W-1:0] bank;
  logic [HIST-1:0]   accHist;
  logic [BANK_W-1:0] bankHist [HIST];
  logic              recentHit;

  assign acc   = reqValid && reqReady;
  assign accRd = acc && !reqWrite;
  assign bank  = reqAddr[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      accHist <= '0;
      for (int k = 0; k < HIST; k++) bankHist[k] <= '0;
    end else begin
      accHist[0]  <= acc;
      bankHist[0] <= bank;
      for (int k = 1; k < HIST; k++) begin
        accHist[k]  <= accHist[k-1];
        bankHist[k] <= bankHist[k-1];
      end
    end
  end

  always_comb begin
    recentHit = 1'b0;
    for (int k = 0; k < HIST; k++)
      if (accHist[k] && bankHist[k] == bank) recentHit = 1'b1;
  end

  AST_BANK_RECOVERY: assert property (@(posedge clk) disable iff (rst)
    acc |-> !recentHit);  // R2
  AST_FREE_BANK_READY: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !recentHit) |-> reqReady);  // R3
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    accRd |=> ##1 rspValid);  // R4
  AST_RSP_HAS_READ: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(accRd, 2));  // R4
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
    $past(acc && reqWrite, 2) |-> !rspValid);  // R5
endmodule

bind ilv_bank_mem ilv_bank_mem_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)
) uChk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqWrite(reqWrite), .reqAddr(reqAddr), .rspValid(rspValid)
);

// File: tb/ilv_bank_mem_test.sv
`timescale 1ns/1ps
module ilv_bank_mem_test;
  localparam int NB = 8, AW = 8, DW = 16, BUSY = 4, WORDS = 1 << AW;

  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [DW-1:0] rspData;

  ilv_bank_mem #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData));

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [WORDS];
  int lastAcc [NB];
  int expCyc[$];
  logic [DW-1:0] expData[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int expAccept(input int present, input int bank);
    int e = lastAcc[bank] + BUSY;
    return (present > e) ? present : e;
  endfunction

  // one access; the timing check is tagged with the requirement under test
  task automatic access(input bit wr, input int addr, input logic [DW-1:0] d,
                        input string req);
    int present, accepted, bank, guard;
    bank = addr % NB;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = AW'(addr); reqWdata = d;
    present = cyc + 1;
    #1;
    guard = 0;
    while (!reqReady && guard < 50) begin
      @(negedge clk); #1; guard++;
    end
    accepted = cyc + 1;
    @(posedge clk);
    check(accepted == expAccept(present, bank), req, accepted, expAccept(present, bank));
    lastAcc[bank] = accepted;
    if (wr) model[addr] = d;
    else begin
      expCyc.push_back(accepted);
      expData.push_back(model[addr]);
    end
    #1 reqValid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // response monitor: R4 latency/data, R5 order and no response for writes
  always @(negedge clk) begin
    if (!rst) begin
      if (expCyc.size() > 0 && expCyc[0] + 1 == cyc) begin
        check(rspValid === 1'b1, "R4 rspValid", int'(rspValid), 1);
        check(rspData === expData[0], "R4/R5 rspData", int'(rspData), int'(expData[0]));
        void'(expCyc.pop_front());
        void'(expData.pop_front());
      end else if (rspValid) begin
        check(1'b0, "R5 unexpected response", 1, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int b = 0; b < NB; b++) lastAcc[b] = -100;
    repeat (4) @(negedge clk);
    rst = 0;
    #1;
    check(reqReady === 1'b1, "R8 reqReady after reset", int'(reqReady), 1);
    check(rspValid === 1'b0, "R8 rspValid after reset", int'(rspValid), 0);

    // fill every word, unit stride: one per cycle
    for (int a = 0; a < WORDS; a++) access(1'b1, a, DW'($urandom), "R6 write stream");
    // unit-stride reads
    for (int a = 0; a < 64; a++) access(1'b0, a, '0, "R6 unit-stride read");
    // stride = bank count: one per BUSY cycles
    for (int i = 0; i < 16; i++) access(1'b0, (3 + i * NB) % WORDS, '0, "R7 bank stride");
    // same address repeated
    for (int i = 0; i < 4; i++) access(1'b0, 77, '0, "R2 same address");
    // same bank, different rows: no aliasing, stall on conflict
    access(1'b1, 40, 16'hA5A5, "R1 write row");
    access(1'b0, 40 + NB, '0, "R1 neighbour row stall");
    access(1'b0, 40, '0, "R1 written row");
    access(1'b0, 41, '0, "R1 next bank no stall");
    // stride 4: two banks alternate
    for (int i = 0; i < 8; i++) access(1'b0, 128 + 4 * i, '0, "R3 stride 4");
    // random strides, mixed writes and idle gaps
    begin
      int addr = 0;
      for (int i = 0; i < 400; i++) begin
        int sel = $urandom % 6;
        int stride = (sel == 5) ? int'($urandom % WORDS) : ((sel == 4) ? NB : (1 << sel));
        addr = (addr + stride) % WORDS;
        if ($urandom % 4 == 0) idle($urandom % 3);
        access(($urandom % 5) == 0, addr, DW'($urandom), "R3 random stream");
      end
    end
    idle(6);
    check(expCyc.size() == 0, "R5 all reads answered", expCyc.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule